// File: doc/BRIEF.md
# Programmable constant countdown timer

A CPU-local timer paced by a fixed-rate tick of 100 MHz (one tick every 10 ns). The tick is made inside the block by dividing the system clock by `TICK_DIV`. A 64-bit configuration word holds an enable flag, a mode flag and a start count. Writing that word with the enable flag set loads the count and starts a countdown. When the countdown runs out, the block latches a level interrupt. It then either reloads the count and keeps going (periodic mode) or clears its own enable flag and halts (one-shot mode).

Next to the countdown, a free-running stable counter adds one on every tick from reset onward. The timer configuration has no effect on it. Software reaches the block through a plain write port and a combinational read port. The read port returns the configuration word, the ticks remaining, the stable counter and the interrupt status. Writing 1 to the clear location drops the interrupt.

Register locations: 0 is the configuration word (read/write), 1 is the remaining ticks (read), 2 is the stable counter (read), 3 is the interrupt status (bit 0 read; writing 1 to bit 0 clears it).

Top module: `ctick_timer`

## Requirements
- R1: After reset, all four read locations return 0 and `irq` is low.
- R2: The stable counter at location 2 increases by exactly one per tick, which is one per `TICK_DIV` (default 2) clocks. This holds whether the timer is running, stopped or being reconfigured.
- R3: A write to location 0 stores the whole word, and location 0 reads it back. When bit 0 of the word is 1, the remaining count at location 1 becomes bits 47:2 of the word with bits 1:0 forced to 0; bits 63:48 are ignored.
- R4: A loaded count of N greater than 0 expires on the N-th tick after the write. A loaded count of 0 expires on the first tick after the write.
- R5: Each expiry sets `irq`, and location 3 bit 0 reads the same value. It stays set until a write of 1 to bit 0 of location 3. Configuration writes and writes of 0 to location 3 leave it set.
- R6: In periodic mode (bit 1 = 1), an expiry reloads the masked count from the configuration word. The next expiry follows N ticks later, and bit 0 stays 1.
- R7: In one-shot mode (bit 1 = 0), an expiry clears bit 0 of the stored word and leaves the remaining count at 0. No further expiry occurs.
- R8: A write to location 0 with bit 0 = 0 stops the countdown. The remaining count holds its value, and no expiry follows.
- R9: A configuration write in the same cycle as an expiry wins. The remaining count takes the written masked value instead of the reload, and a written enable bit of 1 is kept instead of being cleared. The expiry still sets `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write location |
| wr_data | input | 64 | Write data |
| rd_addr | input | 2 | Read location |
| rd_data | output | 64 | Combinational read data |
| irq | output | 1 | Sticky timer interrupt level |

## Verification
A countdown that is off by one tick, or a mask that lets the control bits through, shows up as an expiry interval that differs from the expected N ticks. It is measured against the stable counter within one interval of the write. A lost reload or a missing enable clear shows up at the following expiry: a periodic timer that stays silent, or a one-shot timer that fires again. A wrong priority at a collision shows up on the next read of the remaining count or of the configuration word, one cycle after the colliding edge.

// File: rtl/ctick_timer.sv
module ctick_timer #(
  parameter int DATA_W   = 64,
  parameter int CNT_W    = 48,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0]  pdiv;
  logic [DATA_W-1:0] cfg, stable;
  logic [CNT_W-1:0]  cnt, reload, wr_load;
  logic              tick, cfg_wr, clr_wr, expire;

  assign tick    = (pdiv == DIV_W'(TICK_DIV - 1));
  assign cfg_wr  = wr_en && (wr_addr == 2'd0);
  assign clr_wr  = wr_en && (wr_addr == 2'd3) && wr_data[0];
  assign reload  = {cfg[CNT_W-1:2], 2'b00};
  assign wr_load = {wr_data[CNT_W-1:2], 2'b00};
  assign expire  = tick && cfg[0] && (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pdiv   <= '0;
      stable <= '0;
    end else begin
      pdiv <= tick ? '0 : pdiv + DIV_W'(1);
      if (tick) stable <= stable + DATA_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
      cnt <= '0;
    end else if (cfg_wr) begin
      cfg <= wr_data;
      if (wr_data[0]) cnt <= wr_load;
    end else if (tick && cfg[0]) begin
      if (!expire) cnt <= cnt - CNT_W'(1);
      else if (cfg[1]) cnt <= reload;
      else begin
        cnt    <= '0;
        cfg[0] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      irq <= 1'b0;
    else if (expire) irq <= 1'b1;
    else if (clr_wr) irq <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = cfg;
      2'd1:    rd_data = DATA_W'(cnt);
      2'd2:    rd_data = stable;
      default: rd_data = {{(DATA_W-1){1'b0}}, irq};
    endcase
  end
endmodule

module ctick_timer_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] cfg,
  input logic [DATA_W-1:0] stable,
  input logic [CNT_W-1:0]  cnt,
  input logic              tick,
  input logic              irq
);
  logic cfg_wr_c, clr_c;
  assign cfg_wr_c = wr_en && (wr_addr == 2'd0);
  assign clr_c    = wr_en && (wr_addr == 2'd3) && wr_data[0];

  p_stable_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stable == $past(stable) || stable == $past(stable) + DATA_W'(1)));

  p_cnt_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[0] && (cnt > CNT_W'(1)) && !cfg_wr_c |=>
      (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_c |=> irq);

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cfg[0] && (cnt <= CNT_W'(1)) |=> irq);

  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cfg[0] && !cfg[1] && (cnt <= CNT_W'(1)) && !cfg_wr_c |=>
      (!cfg[0] && cnt == '0));

  p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[0] && !cfg_wr_c |=> $stable(cnt));
endmodule

bind ctick_timer ctick_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cfg(cfg), .stable(stable), .cnt(cnt), .tick(tick), .irq(irq)
);

// File: tb/sim_ctick_timer.sv
`timescale 1ns/1ps
module sim_ctick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [63:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd0;
  logic [63:0] rd_data;
  logic        irq;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  ctick_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [63:0] v0, v1, v2, w;
  int n;

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v0);
      chk("R1 reset read", v0, 64'd0);
    end
    chk("R1 reset irq", {63'd0, irq}, 64'd0);

    rd(2'd2, v0); idle(50); rd(2'd2, v1);
    chk("R2 stable idle", v1 - v0, 64'd25);

    for (int v = 0; v < 16; v++) begin
      for (int m = 0; m < 2; m++) begin
        longint unsigned expt;
        expt = (v == 0) ? 1 : 4 * v;
        w = 64'hA5A5_0000_0000_0000 | (64'(v) << 2) | (64'(m) << 1) | 64'd1;
        wr(2'd3, 64'd1);
        wr(2'd0, w);
        rd(2'd2, v0);
        rd(2'd1, v2);
        chk("R3 masked load", v2, 64'(4 * v));
        rd(2'd0, v2);
        chk("R3 readback", v2, w);
        wait_irq(n);
        rd(2'd2, v1);
        chk("R4 interval", v1 - v0, expt);
        rd(2'd3, v2);
        chk("R5 status bit", v2, 64'd1);
        if (m == 0) begin
          rd(2'd0, v2);
          chk("R7 enable cleared", v2, w & ~64'd1);
          idle(10);
          wr(2'd3, 64'd1);
          idle(2 * int'(expt) + 6);
          rd(2'd1, v2);
          chk("R7 count stays zero", v2, 64'd0);
          chk("R7 no refire", {63'd0, irq}, 64'd0);
        end else if (v != 0) begin
          rd(2'd0, v2);
          chk("R6 enable kept", v2, w);
          wr(2'd3, 64'd1);
          wait_irq(n);
          rd(2'd2, v2);
          chk("R6 reload interval", v2 - v1, expt);
          wr(2'd0, 64'd0);
        end else begin
          wr(2'd0, 64'd0);
        end
      end
    end

    wr(2'd3, 64'd1);
    wr(2'd0, (64'd40 << 2) | 64'd3);
    rd(2'd2, v0);
    idle(30);
    rd(2'd2, v1);
    chk("R2 stable running", v1 - v0, 64'd15);
    wr(2'd0, 64'd40 << 2);
    rd(2'd1, v0);
    idle(200);
    rd(2'd1, v1);
    chk("R8 count frozen", v1, v0);
    chk("R8 no expiry", {63'd0, irq}, 64'd0);
    rd(2'd0, v2);
    chk("R8 readback", v2, 64'd40 << 2);

    wr(2'd0, (64'd1 << 2) | 64'd1);
    wait_irq(n);
    wr(2'd0, (64'd100 << 2) | 64'd1);
    chk("R5 kept over cfg write", {63'd0, irq}, 64'd1);
    wr(2'd3, 64'd0);
    chk("R5 kept over zero clear", {63'd0, irq}, 64'd1);
    wr(2'd3, 64'd1);
    chk("R5 cleared", {63'd0, irq}, 64'd0);

    for (int m = 0; m < 2; m++) begin
      logic [63:0] pv;
      wr(2'd3, 64'd1);
      wr(2'd0, (64'd1 << 2) | (64'(m) << 1) | 64'd1);
      rd(2'd2, pv);
      n = 0;
      forever begin
        @(negedge clk);
        rd(2'd1, v0);
        rd(2'd2, v1);
        n++;
        if ((v0 == 64'd1 && v1 != pv) || n > 100) break;
        pv = v1;
      end
      w = (64'd2 << 2) | (64'(m) << 1) | 64'd1;
      wr(2'd0, w);
      rd(2'd1, v2);
      chk("R9 write beats reload", v2, 64'd8);
      rd(2'd0, v2);
      chk("R9 written enable kept", v2, w);
      chk("R9 expiry still sets irq", {63'd0, irq}, 64'd1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule